// File: doc/BRIEF.md
# Instruction Prefetch Queue with Per-Clock Status

This block holds instruction bytes ahead of the execution side. The bus side fills it with 16-bit word fetches. The execution side takes bytes out one at a time. Prefetching runs alongside execution, so spare bus cycles are spent filling the queue. The queue holds up to six bytes. It asks for a new word only while at least two byte slots are free.

Each clock, the queue reports what happened to it on a 2-bit status output. Logic outside the block can follow the queue contents from that output alone. The status is registered: it is driven at all times and describes the operation of the previous clock. A control transfer flushes the queue and loads a new fetch pointer. When that pointer is odd, the next word fetched gives up only its upper byte.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted and after it is released, the queue is empty (`rd_valid_o` low), the status reads 00, `fetch_req_o` is high, and the fetch pointer is 0.
- R2: `fetch_req_o` is high exactly when the queue holds at most four bytes, so that at least two slots are free.
- R3: `fetch_addr_o` is the fetch pointer with bit 0 cleared. When the pointer is even, an accepted fetch (`fetch_req_o` and `fetch_ack_i`) appends `fetch_data_i[7:0]` and then `fetch_data_i[15:8]`, and the pointer advances by 2.
- R4: When the pointer is odd, an accepted fetch appends only `fetch_data_i[15:8]`, and the pointer advances by 1.
- R5: Bytes leave in the order they arrived. `rd_data_o` shows the oldest byte and `rd_valid_o` is high when the queue is not empty. A read (`rd_i`) on a non-empty queue removes that byte.
- R6: A read on an empty queue is not granted, changes nothing, and gives status 00 in the next clock.
- R7: A granted read gives status 01 in the next clock when `rd_first_i` is high (first opcode byte) and 11 when it is low (subsequent byte). A clock with no queue operation gives status 00.
- R8: A flush (`flush_i`) empties the queue, loads `flush_addr_i` into the fetch pointer, and gives status 10 in the next clock. It overrides a read and a fetch acknowledge in the same clock, so neither takes effect.
- R9: The queue never holds more than six bytes. A queue filled to six bytes hands all six back in order, and this holds across storage wrap-around.
- R10: A fetch acknowledge arriving while `fetch_req_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Control transfer: empty the queue and reload the pointer |
| flush_addr_i | input | ADDR_W | New fetch pointer, loaded on flush |
| fetch_req_o | output | 1 | Queue has room for a word fetch |
| fetch_addr_o | output | ADDR_W | Word-aligned fetch address |
| fetch_ack_i | input | 1 | Fetch data is valid this clock |
| fetch_data_i | input | 16 | Fetched word |
| rd_i | input | 1 | Execution side takes a byte |
| rd_first_i | input | 1 | The byte taken is the first byte of an opcode |
| rd_valid_o | output | 1 | Queue is not empty |
| rd_data_o | output | 8 | Oldest queued byte |
| qstat_o | output | 2 | Registered queue operation of the previous clock |

## Verification
The hardest cases to reach are the collisions, where a flush lands in the same clock as a read or a fetch acknowledge. Close behind is an odd fetch pointer, which only a flush can create. A vector table drives these collisions one after another, from a state where the queue is known to hold bytes. Each loss then shows up at the ports as an empty queue and a status of 10. A directed run then fills the queue, drains it to one byte and refills it, so the storage indices wrap while the byte order is checked.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    typedef struct packed {
        logic [1:0]        nbytes;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } push_t;

    function automatic qstat_e qstat_of(logic flush, logic grant, logic first);
        if (flush)
            return QS_FLUSH;
        else if (grant)
            return first ? QS_FIRST : QS_NEXT;
        else
            return QS_IDLE;
    endfunction

endpackage

// File: rtl/pfq_store.sv
module pfq_store
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  push_t             push,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [CNT_W-1:0]  count
);

    localparam int SW = IDX_W + 1;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [IDX_W-1:0] bump(logic [IDX_W-1:0] i, int unsigned k);
        logic [SW-1:0] s;
        s = {1'b0, i} + SW'(k);
        if (s >= SW'(DEPTH))
            s = s - SW'(DEPTH);
        return s[IDX_W-1:0];
    endfunction

    logic [IDX_W-1:0] wr_idx_b;
    assign wr_idx_b = bump(wr_idx, 1);

    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (!clear && push.nbytes != 2'd0 && IDX_W'(e) == wr_idx)
                mem[e] <= push.lo;
            else if (!clear && push.nbytes == 2'd2 && IDX_W'(e) == wr_idx_b)
                mem[e] <= push.hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_idx <= '0;
            rd_idx <= '0;
            cnt_q  <= '0;
        end else begin
            wr_idx <= bump(wr_idx, 32'(push.nbytes));
            if (pop)
                rd_idx <= bump(rd_idx, 1);
            cnt_q <= cnt_q + CNT_W'(push.nbytes) - CNT_W'(pop);
        end
    end

    assign head  = mem[rd_idx];
    assign count = cnt_q;

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              ack,
    input  logic [WORD_W-1:0] data,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output push_t             push
);

    logic [ADDR_W-1:0] ptr_q;
    logic              take;

    assign req  = count <= CNT_W'(DEPTH - 2);
    assign take = req && ack && !flush;
    assign addr = {ptr_q[ADDR_W-1:1], 1'b0};

    always_comb begin
        push = '0;
        if (take) begin
            if (ptr_q[0]) begin
                push.nbytes = 2'd1;
                push.lo     = data[WORD_W-1:BYTE_W];
            end else begin
                push.nbytes = 2'd2;
                push.lo     = data[BYTE_W-1:0];
                push.hi     = data[WORD_W-1:BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (flush)
            ptr_q <= flush_addr;
        else if (take)
            ptr_q <= ptr_q + (ptr_q[0] ? ADDR_W'(1) : ADDR_W'(2));
    end

endmodule

// File: rtl/pfq_status.sv
module pfq_status
    import pfq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   grant,
    input  logic   first,
    output qstat_e qstat
);

    always_ff @(posedge clk) begin
        if (rst)
            qstat <= QS_IDLE;
        else
            qstat <= qstat_of(flush, grant, first);
    end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_addr_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_ack_i,
    input  logic [15:0]       fetch_data_i,
    input  logic              rd_i,
    input  logic              rd_first_i,
    output logic              rd_valid_o,
    output logic [7:0]        rd_data_o,
    output logic [1:0]        qstat_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] fill;
    push_t            push;
    logic             grant;
    qstat_e           qstat;

    assign rd_valid_o = fill != '0;
    assign grant      = rd_i && rd_valid_o && !flush_i;

    pfq_fetch #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_i),
        .flush_addr (flush_addr_i),
        .count      (fill),
        .ack        (fetch_ack_i),
        .data       (fetch_data_i),
        .req        (fetch_req_o),
        .addr       (fetch_addr_o),
        .push       (push)
    );

    pfq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clear (flush_i),
        .push  (push),
        .pop   (grant),
        .head  (rd_data_o),
        .count (fill)
    );

    pfq_status u_status (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_i),
        .grant (grant),
        .first (rd_first_i),
        .qstat (qstat)
    );

    assign qstat_o = qstat;

endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_i,
    input logic              rd_i,
    input logic              rd_first_i,
    input logic              rd_valid_o,
    input logic              fetch_req_o,
    input logic              fetch_ack_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [1:0]        qstat_o,
    input logic [CNT_W-1:0]  fill
);

    // R9
    cap_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R3
    even_addr_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req_o |-> fetch_addr_o[0] == 1'b0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_req_o && !rd_i && !flush_i) |=> $stable(fill));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !rd_valid_o && !flush_i) |=> qstat_o == 2'b00);

    // R7
    first_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && rd_valid_o && !flush_i && rd_first_i) |=> qstat_o == 2'b01);

    // R7
    next_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && rd_valid_o && !flush_i && !rd_first_i) |=> qstat_o == 2'b11);

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (qstat_o == 2'b10 && !rd_valid_o));

endmodule

bind prefetch_queue prefetch_queue_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .rd_i         (rd_i),
    .rd_first_i   (rd_first_i),
    .rd_valid_o   (rd_valid_o),
    .fetch_req_o  (fetch_req_o),
    .fetch_ack_i  (fetch_ack_i),
    .fetch_addr_o (fetch_addr_o),
    .qstat_o      (qstat_o),
    .fill         (fill)
);

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;

    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst;
    logic              flush_i;
    logic [ADDR_W-1:0] flush_addr_i;
    logic              fetch_req_o;
    logic [ADDR_W-1:0] fetch_addr_o;
    logic              fetch_ack_i;
    logic [15:0]       fetch_data_i;
    logic              rd_i;
    logic              rd_first_i;
    logic              rd_valid_o;
    logic [7:0]        rd_data_o;
    logic [1:0]        qstat_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prefetch_queue #(.ADDR_W(ADDR_W), .DEPTH(6)) u_prefetch_queue (.*);

    typedef struct packed {
        logic        fl;
        logic [7:0]  fa;
        logic        rd;
        logic        fi;
        logic        ak;
        logic [15:0] dat;
        logic [1:0]  eq;
        logic        er;
        logic        ev;
        logic [7:0]  eh;
        logic [7:0]  ea;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 16'h0000, 2'b10, 1'b1, 1'b0, 8'h00, 8'h10}, // R8 flush
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hB1A0, 2'b00, 1'b1, 1'b1, 8'hA0, 8'h12}, // R3 even word
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 16'hD3C2, 2'b01, 1'b1, 1'b1, 8'hB1, 8'h14}, // R7 first
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 16'hF5E4, 2'b11, 1'b1, 1'b1, 8'hC2, 8'h16}, // R7 next
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h1706, 2'b00, 1'b0, 1'b1, 8'hC2, 8'h18}, // R2 full
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h9988, 2'b00, 1'b0, 1'b1, 8'hC2, 8'h18}, // R10 ignored ack
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 2'b11, 1'b0, 1'b1, 8'hD3, 8'h18}, // R5 order
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0000, 2'b01, 1'b1, 1'b1, 8'hE4, 8'h18}, // R2 room again
        '{1'b1, 8'h21, 1'b1, 1'b1, 1'b0, 16'h0000, 2'b10, 1'b1, 1'b0, 8'h00, 8'h20}, // R8 beats read
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 16'h5544, 2'b00, 1'b1, 1'b1, 8'h55, 8'h22}, // R4 odd, R6 stall
        '{1'b1, 8'h30, 1'b0, 1'b0, 1'b1, 16'h7766, 2'b10, 1'b1, 1'b0, 8'h00, 8'h30}, // R8 beats ack
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b1, 1'b0, 8'h00, 8'h30}, // R6 empty read
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h2211, 2'b00, 1'b1, 1'b1, 8'h11, 8'h32}, // R3
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0000, 2'b01, 1'b1, 1'b1, 8'h22, 8'h32}, // R7
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 1'b0, 8'h00, 8'h32}, // R5 drained
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b1, 1'b0, 8'h00, 8'h32}  // R7 idle
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(logic fl, logic [7:0] fa, logic rd, logic fi, logic ak, logic [15:0] dat);
        @(negedge clk);
        flush_i      = fl;
        flush_addr_i = ADDR_W'(fa);
        rd_i         = rd;
        rd_first_i   = fi;
        fetch_ack_i  = ak;
        fetch_data_i = dat;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        flush_i = 1'b0; flush_addr_i = '0; rd_i = 1'b0; rd_first_i = 1'b0;
        fetch_ack_i = 1'b0; fetch_data_i = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 qstat", 32'(qstat_o), 32'h0);
        chk("R1 valid", 32'(rd_valid_o), 32'h0);
        chk("R1 req", 32'(fetch_req_o), 32'h1);
        chk("R1 addr", 32'(fetch_addr_o), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].fl, VEC[i].fa, VEC[i].rd, VEC[i].fi, VEC[i].ak, VEC[i].dat);
            chk($sformatf("R7 qstat row %0d", i), 32'(qstat_o), 32'(VEC[i].eq));
            chk($sformatf("R2 req row %0d", i), 32'(fetch_req_o), 32'(VEC[i].er));
            chk($sformatf("R5 valid row %0d", i), 32'(rd_valid_o), 32'(VEC[i].ev));
            if (VEC[i].ev)
                chk($sformatf("R5 head row %0d", i), 32'(rd_data_o), 32'(VEC[i].eh));
            chk($sformatf("R3 addr row %0d", i), 32'(fetch_addr_o), 32'(VEC[i].ea));
        end

        // R9 fill to six, drain to one, refill across wrap
        step(1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 16'h0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0100);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0302);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0504);
        chk("R9 full req", 32'(fetch_req_o), 32'h0);
        for (int k = 0; k < 5; k++) begin
            chk("R9 order", 32'(rd_data_o), 32'(k));
            step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
        end
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0706);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0908);
        chk("R2 five held", 32'(fetch_req_o), 32'h0);
        for (int k = 5; k < 10; k++) begin
            chk("R9 wrap order", 32'(rd_data_o), 32'(k));
            step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
        end
        chk("R9 drained", 32'(rd_valid_o), 32'h0);

        // R1 reset in mid-run
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hAAAA);
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0);
        @(negedge clk);
        rst = 1'b1; rd_i = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 rerst qstat", 32'(qstat_o), 32'h0);
        chk("R1 rerst valid", 32'(rd_valid_o), 32'h0);
        chk("R1 rerst addr", 32'(fetch_addr_o), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule